// File: doc/BRIEF.md
# SPI Master Controller with Register Bus

This block is a serial peripheral interface master driven from a simple word-wide register bus. Software writes bytes into a transmit queue; the controller shifts each byte out most significant bit first on `mosi` while capturing the same number of bits from `miso`, and places every completed receive byte in a receive queue that software pops through a data register. Both queues hold 128 bytes by default. The serial clock runs at the reference clock divided by a power of two chosen by a 3-bit code. Clock polarity and phase select among the four usual SPI modes.

Four active-low slave selects are taken from a one-cold field in the control register. In manual select mode the lines follow that field at all times. In automatic mode they show the field only while a byte is in flight. Transmission can start automatically whenever data is queued, or it can wait for an explicit start command. An interrupt line is the OR of the status bits that the running mask enables. Status bits that record events are cleared by writing ones.

Register offsets: 0x00 control, 0x04 status, 0x08 mask set, 0x0C mask clear, 0x10 mask read, 0x14 enable, 0x18 delay (storage only), 0x1C transmit data, 0x20 receive data. Control bits: 0 master, 1 clock polarity, 2 clock phase, 5:3 divider code, 13:10 select field, 14 manual select, 15 manual start, 16 start command (write only, reads 0). Status bits: 0 receive overflow, 1 byte done, 2 transmit not full, 3 transmit full, 4 receive not empty, 5 receive full, 6 transmit overflow.

Top module: `spim_ctrl`

## Requirements
- R1: After reset, control reads 0x00003C00, enable reads 0, mask reads 0, status reads 0x04, `ss_n` is all ones, `sclk` is low and `irq` is low.
- R2: While a byte is in flight, consecutive `sclk` edges are exactly 2^code reference clocks apart, where code is control bits 5:3, so one serial clock period is (2 << code) reference clocks.
- R3: When no byte is in flight, `sclk` equals control bit 1. With control bit 2 clear, data is sampled on the first edge of each bit; with it set, on the second edge. `mosi` is stable across every sampling edge.
- R4: Each byte is sent most significant bit first, eight bits per byte, and the eight `miso` bits captured on the sampling edges form the received byte with the first bit as its most significant bit.
- R5: With control bit 14 set, `ss_n` equals control bits 13:10 at all times (1110 selects slave 0, 1101 slave 1, 1011 slave 2). With it clear, `ss_n` shows that field only while a byte is in flight and is all ones otherwise.
- R6: With control bit 15 clear, a byte starts whenever enable bit 0 and control bit 0 are set and the transmit queue is not empty. With control bit 15 set, queued bytes wait until a control write with bit 16 set, after which the queue is sent until empty.
- R7: Writing 0 to enable bit 0 stops shifting within two clocks: `sclk` returns to its idle level and the byte in flight is discarded without entering the receive queue.
- R8: Each queue holds 128 bytes. Status bits 2, 3, 4 and 5 report transmit not full, transmit full, receive not empty and receive full as live levels.
- R9: A transmit-data write while the transmit queue is full is dropped and sets status bit 6. A byte completing while the receive queue is full is dropped and sets status bit 0. Status bit 1 is set each time a byte completes.
- R10: Writing ones to the status register clears the matching event bits 0, 1 and 6; the level bits 2 to 5 are not changed by such a write.
- R11: Reading the receive-data register returns the oldest received byte in bits 7:0 and removes it; when the queue is empty, the read returns 0.
- R12: Writing the mask-set register sets the written one bits of the mask, writing the mask-clear register clears them, the mask-read register returns the mask, and `irq` is high exactly when some status bit and its mask bit are both set.
- R13: The delay register at 0x18 stores and returns a 32-bit value and has no effect on the serial interface.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops receive data) |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the current address |
| irq | output | 1 | Interrupt request |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 4 | Active-low slave selects |

## Verification
A corrupted shift register or bit counter shows on `mosi` within the byte it affects and in the received byte as soon as software pops it, because the bench loops `mosi` back to `miso`, sometimes inverted. A wrong divider count shows at the next `sclk` edge as a spacing error, and a stale busy state shows as `sclk` or `ss_n` off their idle levels as soon as a transfer should have ended. Queue pointer or count faults surface at the status register within the cycle after the push or pop, and as a wrong byte order after a full 128-byte fill and drain.

// File: rtl/spim_pkg.sv
// Shared constants for the SPI master controller: register offsets,
// control and status bit positions, reset values.
package spim_pkg;
    localparam int REG_AW = 8;
    localparam int SS_W   = 4;
    localparam int BAUD_W = 3;
    localparam int STAT_W = 7;

    localparam logic [REG_AW-1:0] OFF_CTRL  = 8'h00;
    localparam logic [REG_AW-1:0] OFF_STAT  = 8'h04;
    localparam logic [REG_AW-1:0] OFF_MSET  = 8'h08;
    localparam logic [REG_AW-1:0] OFF_MCLR  = 8'h0C;
    localparam logic [REG_AW-1:0] OFF_MASK  = 8'h10;
    localparam logic [REG_AW-1:0] OFF_EN    = 8'h14;
    localparam logic [REG_AW-1:0] OFF_DLY   = 8'h18;
    localparam logic [REG_AW-1:0] OFF_TXD   = 8'h1C;
    localparam logic [REG_AW-1:0] OFF_RXD   = 8'h20;

    localparam int CB_MASTER = 0;
    localparam int CB_CPOL   = 1;
    localparam int CB_CPHA   = 2;
    localparam int CB_BAUD   = 3;
    localparam int CB_SS     = 10;
    localparam int CB_MCS    = 14;
    localparam int CB_MSTART = 15;
    localparam int CB_GO     = 16;

    localparam int SB_RXOV = 0;
    localparam int SB_DONE = 1;
    localparam int SB_TXNF = 2;
    localparam int SB_TXF  = 3;
    localparam int SB_RXNE = 4;
    localparam int SB_RXF  = 5;
    localparam int SB_TXOV = 6;

    // Control fields held by the register block.
    typedef struct packed {
        logic              mstart;
        logic              mcs;
        logic [SS_W-1:0]   ss;
        logic [BAUD_W-1:0] baud;
        logic              cpha;
        logic              cpol;
        logic              master;
    } ctrl_t;
endpackage

// File: rtl/spim_fifo.sv
// Synchronous first-in first-out queue.
// Assumes DEPTH is a power of two; push when full and pop when empty are ignored.
// Read data shows the oldest entry combinationally.
module spim_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 128
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [W-1:0]                 din,
    input  logic                         pop,
    output logic [W-1:0]                 dout,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         empty,
    output logic                         full
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == FULL_CNT);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    // Store a pushed entry.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // Advance pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/spim_clkdiv.sv
// Half-period timer for the serial clock.
// While run is high it pulses tick every 2^code reference clocks;
// while run is low it holds at zero so the next half starts complete.
module spim_clkdiv #(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [CODE_W-1:0] code,
    output logic              tick
);
    localparam int DCW = (1 << CODE_W) - 1;

    logic [DCW-1:0] cnt;
    logic [DCW-1:0] lim;

    assign lim  = DCW'(({{DCW{1'b0}}, 1'b1} << code) - 1'b1);
    assign tick = run && (cnt == lim);

    // Count reference clocks within the current half period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) cnt <= '0;
        else                        cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/spim_shift.sv
// Byte shift engine: takes a byte from the transmit queue, runs 2*DW half
// periods of the serial clock, sends MSB first and samples on the even-half
// boundaries, then reports the captured byte. Dropping run aborts the byte.
module spim_shift #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          may_start,
    input  logic          tx_empty,
    input  logic [DW-1:0] tx_data,
    input  logic          cpol,
    input  logic          cpha,
    input  logic          tick,
    input  logic          miso,
    output logic          tx_pop,
    output logic          byte_done,
    output logic [DW-1:0] rx_data,
    output logic          busy,
    output logic          sclk,
    output logic          mosi
);
    localparam int HCW = $clog2(2*DW);
    localparam logic [HCW-1:0] LAST = HCW'(2*DW-1);

    logic           busy_q;
    logic [HCW-1:0] half_q;
    logic [DW-1:0]  tx_sh, rx_sh;
    logic           start;

    assign start     = run && !busy_q && may_start && !tx_empty;
    assign tx_pop    = start;
    assign byte_done = run && busy_q && tick && (half_q == LAST);
    assign rx_data   = rx_sh;
    assign busy      = busy_q;
    assign sclk      = busy_q ? (cpol ^ (cpha ? ~half_q[0] : half_q[0])) : cpol;
    assign mosi      = busy_q && tx_sh[DW-1];

    // Sequence one byte through its half periods.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            half_q <= '0;
            tx_sh  <= '0;
            rx_sh  <= '0;
        end else if (!run) begin
            busy_q <= 1'b0;
            half_q <= '0;
        end else if (!busy_q) begin
            if (start) begin
                busy_q <= 1'b1;
                half_q <= '0;
                tx_sh  <= tx_data;
            end
        end else if (tick) begin
            if (!half_q[0])          rx_sh <= {rx_sh[DW-2:0], miso};
            else if (half_q != LAST) tx_sh <= {tx_sh[DW-2:0], 1'b0};
            if (half_q == LAST)      busy_q <= 1'b0;
            half_q <= half_q + 1'b1;
        end
    end
endmodule

// File: rtl/spim_ctrl.sv
// SPI master controller top: register bank, transmit and receive queues,
// divider and shift engine. Assumes single-cycle register strobes; a read
// of the receive-data offset pops one byte at the clock edge.
module spim_ctrl
    import spim_pkg::*;
#(
    parameter int FIFO_DEPTH = 128,
    parameter int DATA_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [SS_W-1:0]   ss_n
);
    localparam int CNT_W = $clog2(FIFO_DEPTH+1);

    ctrl_t             ctrl_q;
    logic              en_q;
    logic              go_q;
    logic [STAT_W-1:0] mask_q;
    logic              st_rxov, st_done, st_txov;
    logic [31:0]       dly_q;

    logic              tx_wr, tx_pop, tx_empty, tx_full;
    logic [DATA_W-1:0] tx_dout;
    logic [CNT_W-1:0]  tx_count;
    logic              rx_rd, rx_push, rx_empty, rx_full;
    logic [DATA_W-1:0] rx_dout, rx_byte;
    logic [CNT_W-1:0]  rx_count;

    logic              run, may_start, tick, eng_busy, byte_done;
    logic              wr_ctrl, wr_stat, wr_mset, wr_mclr;
    logic [STAT_W-1:0] status;

    assign wr_ctrl = reg_wr && (reg_addr == OFF_CTRL);
    assign wr_stat = reg_wr && (reg_addr == OFF_STAT);
    assign wr_mset = reg_wr && (reg_addr == OFF_MSET);
    assign wr_mclr = reg_wr && (reg_addr == OFF_MCLR);
    assign tx_wr   = reg_wr && (reg_addr == OFF_TXD);
    assign rx_rd   = reg_rd && (reg_addr == OFF_RXD);

    assign run       = en_q && ctrl_q.master;
    assign may_start = !ctrl_q.mstart || go_q;
    assign rx_push   = byte_done;

    spim_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(tx_wr), .din(reg_wdata[DATA_W-1:0]),
        .pop(tx_pop), .dout(tx_dout), .count(tx_count), .empty(tx_empty), .full(tx_full)
    );

    spim_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_byte),
        .pop(rx_rd), .dout(rx_dout), .count(rx_count), .empty(rx_empty), .full(rx_full)
    );

    spim_clkdiv #(.CODE_W(BAUD_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(eng_busy), .code(ctrl_q.baud), .tick(tick)
    );

    spim_shift #(.DW(DATA_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .run(run), .may_start(may_start),
        .tx_empty(tx_empty), .tx_data(tx_dout), .cpol(ctrl_q.cpol), .cpha(ctrl_q.cpha),
        .tick(tick), .miso(miso), .tx_pop(tx_pop), .byte_done(byte_done),
        .rx_data(rx_byte), .busy(eng_busy), .sclk(sclk), .mosi(mosi)
    );

    // Control, enable, delay and mask registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '{mstart: 1'b0, mcs: 1'b0, ss: '1, baud: '0,
                        cpha: 1'b0, cpol: 1'b0, master: 1'b0};
            en_q   <= 1'b0;
            mask_q <= '0;
            dly_q  <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.master <= reg_wdata[CB_MASTER];
                ctrl_q.cpol   <= reg_wdata[CB_CPOL];
                ctrl_q.cpha   <= reg_wdata[CB_CPHA];
                ctrl_q.baud   <= reg_wdata[CB_BAUD +: BAUD_W];
                ctrl_q.ss     <= reg_wdata[CB_SS +: SS_W];
                ctrl_q.mcs    <= reg_wdata[CB_MCS];
                ctrl_q.mstart <= reg_wdata[CB_MSTART];
            end
            if (reg_wr && reg_addr == OFF_EN)  en_q  <= reg_wdata[0];
            if (reg_wr && reg_addr == OFF_DLY) dly_q <= reg_wdata;
            if (wr_mset)      mask_q <= mask_q | reg_wdata[STAT_W-1:0];
            else if (wr_mclr) mask_q <= mask_q & ~reg_wdata[STAT_W-1:0];
        end
    end

    // Pending start command for manual-start mode; retires once the queue is sent.
    always_ff @(posedge clk) begin
        if (!rst_n || !ctrl_q.mstart) go_q <= 1'b0;
        else if (wr_ctrl && reg_wdata[CB_GO] && reg_wdata[CB_MSTART]) go_q <= 1'b1;
        else if (go_q && !eng_busy && tx_empty) go_q <= 1'b0;
    end

    // Sticky event bits: set by events, cleared by writing ones; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_rxov <= 1'b0;
            st_done <= 1'b0;
            st_txov <= 1'b0;
        end else begin
            st_rxov <= (st_rxov && !(wr_stat && reg_wdata[SB_RXOV])) || (byte_done && rx_full);
            st_done <= (st_done && !(wr_stat && reg_wdata[SB_DONE])) || byte_done;
            st_txov <= (st_txov && !(wr_stat && reg_wdata[SB_TXOV])) || (tx_wr && tx_full);
        end
    end

    // Assemble the status word.
    always_comb begin
        status          = '0;
        status[SB_RXOV] = st_rxov;
        status[SB_DONE] = st_done;
        status[SB_TXNF] = !tx_full;
        status[SB_TXF]  = tx_full;
        status[SB_RXNE] = !rx_empty;
        status[SB_RXF]  = rx_full;
        status[SB_TXOV] = st_txov;
    end

    // Read-data multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFF_CTRL: begin
                reg_rdata[CB_MASTER]            = ctrl_q.master;
                reg_rdata[CB_CPOL]              = ctrl_q.cpol;
                reg_rdata[CB_CPHA]              = ctrl_q.cpha;
                reg_rdata[CB_BAUD +: BAUD_W]    = ctrl_q.baud;
                reg_rdata[CB_SS +: SS_W]        = ctrl_q.ss;
                reg_rdata[CB_MCS]               = ctrl_q.mcs;
                reg_rdata[CB_MSTART]            = ctrl_q.mstart;
            end
            OFF_STAT: reg_rdata[STAT_W-1:0] = status;
            OFF_MASK: reg_rdata[STAT_W-1:0] = mask_q;
            OFF_EN:   reg_rdata[0]          = en_q;
            OFF_DLY:  reg_rdata             = dly_q;
            OFF_RXD:  reg_rdata[DATA_W-1:0] = rx_empty ? '0 : rx_dout;
            default:  reg_rdata             = '0;
        endcase
    end

    assign irq  = |(status & mask_q);
    assign ss_n = (ctrl_q.mcs || eng_busy) ? ctrl_q.ss : '1;
endmodule

// File: rtl/spim_ctrl_chk.sv
// Property checker for spim_ctrl, attached by bind. Observes engine state,
// queue counts and outputs; drives nothing.
module spim_ctrl_chk #(
    parameter int DEPTH = 128,
    parameter int CW    = 8,
    parameter int SSW   = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           en,
    input logic           busy,
    input logic           cpol,
    input logic           mcs,
    input logic           sclk,
    input logic [SSW-1:0] ss_n,
    input logic           tx_wr,
    input logic           tx_full,
    input logic           st_txov,
    input logic           rx_rd,
    input logic           rx_empty,
    input logic           rx_push,
    input logic [CW-1:0]  rx_count,
    input logic [CW-1:0]  tx_count
);
    p_sclk_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sclk == cpol);

    p_ss_auto_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mcs && !busy) |-> ss_n == {SSW{1'b1}});

    p_halt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !busy);

    p_count_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count <= CW'(DEPTH)) && (rx_count <= CW'(DEPTH)));

    p_tx_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr && tx_full) |=> st_txov);

    p_rx_pop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rd && !rx_empty && !rx_push) |=> rx_count == $past(rx_count) - 1'b1);
endmodule

bind spim_ctrl spim_ctrl_chk #(.DEPTH(FIFO_DEPTH), .CW(CNT_W), .SSW(spim_pkg::SS_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .en(en_q), .busy(eng_busy), .cpol(ctrl_q.cpol),
    .mcs(ctrl_q.mcs), .sclk(sclk), .ss_n(ss_n), .tx_wr(tx_wr), .tx_full(tx_full),
    .st_txov(st_txov), .rx_rd(rx_rd), .rx_empty(rx_empty), .rx_push(rx_push),
    .rx_count(rx_count), .tx_count(tx_count)
);

// File: tb/sim_spim_ctrl.sv
`timescale 1ns/1ps
// Bench for spim_ctrl: loopback slave (optionally inverting), a bus monitor
// that decodes mosi at the sampling edges and times sclk edges, and random
// plus directed register sequences.
module sim_spim_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq, sclk, mosi, miso;
    logic [3:0]  ss_n;
    logic        inv = 1'b0;

    int checks = 0, errors = 0;
    int mon_checks = 0, mon_errs = 0;
    logic mon_resync = 1'b1;

    logic       c_master = 1'b1, c_cpol = 1'b0, c_cpha = 1'b0;
    logic       c_mcs = 1'b1, c_mstart = 1'b0;
    logic [2:0] c_code = '0;
    logic [3:0] c_ss = 4'hF;
    int         cfg_half = 1;

    logic [7:0] exp_tx [1024];
    logic [7:0] exp_rx [1024];
    int wi = 0, ei = 0, ri = 0;

    always #10 clk = ~clk;

    assign miso = inv ? ~mosi : mosi;

    spim_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n)
    );

    // ---------------- monitor: R2 edge spacing, R3/R4 mosi decode ----------
    logic       prev_sclk = 1'b0;
    int         cyc = 0, eidx = 0, nb = 0, mrd = 0;
    logic       sp_bad = 1'b0;
    logic [7:0] cap = '0;

    always @(negedge clk) begin
        if (!rst_n || mon_resync) begin
            prev_sclk = sclk; cyc = 0; eidx = 0; nb = 0; sp_bad = 1'b0;
        end else begin
            cyc = cyc + 1;
            if (sclk != prev_sclk) begin
                if ((eidx % 16) != 0 && cyc != cfg_half) sp_bad = 1'b1;
                cyc = 0;
                eidx = eidx + 1;
                if (sclk == ~(c_cpol ^ c_cpha)) begin
                    cap = {cap[6:0], mosi};
                    nb = nb + 1;
                    if (nb == 8) begin
                        mon_checks = mon_checks + 1;
                        if (cap != exp_tx[mrd % 1024] || sp_bad) begin
                            mon_errs = mon_errs + 1;
                            $display("FAIL R2/R4 mosi byte act=%02h exp=%02h spacing_bad=%0d half=%0d",
                                     cap, exp_tx[mrd % 1024], sp_bad, cfg_half);
                        end
                        mrd = mrd + 1; nb = 0; sp_bad = 1'b0;
                    end
                end
            end
            prev_sclk = sclk;
        end
    end

    // ---------------- helpers ----------------------------------------------
    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s act=%08h exp=%08h", tag, act, exp);
        end
    endtask

    task automatic bwr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic brd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #5 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    function automatic logic [31:0] ctrl_word(input logic go);
        return {15'b0, go, c_mstart, c_mcs, c_ss, 4'b0, c_code, c_cpha, c_cpol, c_master};
    endfunction

    task automatic set_cfg;
        mon_resync = 1'b1;
        cfg_half = 1 << c_code;
        bwr(8'h00, ctrl_word(1'b0));
        repeat (2) @(negedge clk);
        mon_resync = 1'b0;
    endtask

    task automatic push_byte(input logic [7:0] b, input logic to_rx);
        exp_tx[wi % 1024] = b; wi = wi + 1;
        if (to_rx) begin exp_rx[ei % 1024] = inv ? ~b : b; ei = ei + 1; end
        bwr(8'h1C, {24'b0, b});
    endtask

    task automatic wait_bytes(input int n);
        repeat (n * (16 * cfg_half + 2) + 20) @(negedge clk);
    endtask

    task automatic drain(input int n, input string tag);
        logic [31:0] v;
        for (int i = 0; i < n; i++) begin
            brd(8'h20, v);
            check(v, {24'b0, exp_rx[ri % 1024]}, tag);
            ri = ri + 1;
        end
    endtask

    task automatic finish_run;
        $display("CHECKS %0d ERRORS %0d", checks + mon_checks, errors + mon_errs);
        $finish;
    endtask

    // ---------------- watchdog ---------------------------------------------
    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks + mon_checks + 1, errors + mon_errs + 1);
        $finish;
    end

    // ---------------- stimulus ---------------------------------------------
    initial begin
        logic [31:0] v;
        int n;
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        brd(8'h00, v); check(v, 32'h0000_3C00, "R1 ctrl");
        brd(8'h04, v); check(v, 32'h4, "R1 status");
        brd(8'h10, v); check(v, 32'h0, "R1 mask");
        brd(8'h14, v); check(v, 32'h0, "R1 enable");
        check({28'b0, ss_n}, 32'hF, "R1 ss_n");
        check({31'b0, sclk}, 32'h0, "R1 sclk");
        check({31'b0, irq}, 32'h0, "R1 irq");

        // R13: delay register storage
        bwr(8'h18, 32'hA5C3_1E70); brd(8'h18, v); check(v, 32'hA5C3_1E70, "R13 delay");

        // R5: manual select follows the field
        c_ss = 4'hE; set_cfg(); check({28'b0, ss_n}, 32'hE, "R5 slave0");
        c_ss = 4'hD; set_cfg(); check({28'b0, ss_n}, 32'hD, "R5 slave1");
        c_ss = 4'hB; set_cfg(); check({28'b0, ss_n}, 32'hB, "R5 slave2");
        c_ss = 4'hE; set_cfg();

        bwr(8'h14, 32'h1);

        // R2/R3/R4: random bytes over all four modes and several dividers
        for (int k = 0; k < 8; k++) begin
            c_cpol = k[0]; c_cpha = k[1];
            c_code = (k == 7) ? 3'd7 : 3'($urandom % 4);
            inv = 1'($urandom % 2);
            set_cfg();
            n = (k == 7) ? 1 : 1 + int'($urandom % 5);
            for (int j = 0; j < n; j++) push_byte(8'($urandom), 1'b1);
            wait_bytes(n);
            check({31'b0, sclk}, {31'b0, c_cpol}, "R3 idle level");
            brd(8'h04, v); check(v & 32'h12, 32'h12, "R9 done and R8 rx not empty");
            drain(n, "R4 received byte");
        end
        brd(8'h04, v); check(v, 32'h06, "R8 levels after drain");
        bwr(8'h04, 32'h02);
        brd(8'h04, v); check(v, 32'h04, "R10 clear done");

        // R5: automatic select only while a byte is in flight
        c_cpol = 1'b0; c_cpha = 1'b0; c_code = 3'd1; c_mcs = 1'b0; inv = 1'b0;
        set_cfg();
        check({28'b0, ss_n}, 32'hF, "R5 auto idle");
        push_byte(8'h3C, 1'b1); push_byte(8'hC5, 1'b1);
        repeat (6) @(negedge clk);
        check({28'b0, ss_n}, 32'hE, "R5 auto active");
        wait_bytes(2);
        check({28'b0, ss_n}, 32'hF, "R5 auto after");
        drain(2, "R4 auto bytes");

        // R6: manual start waits for the start command
        c_mcs = 1'b1; c_mstart = 1'b1; set_cfg();
        push_byte(8'h81, 1'b1); push_byte(8'h7E, 1'b1); push_byte(8'h00, 1'b1);
        repeat (200) @(negedge clk);
        brd(8'h04, v); check(v & 32'h10, 32'h0, "R6 held without start");
        check({31'b0, sclk}, 32'h0, "R6 sclk idle while held");
        bwr(8'h00, ctrl_word(1'b1));
        wait_bytes(3);
        drain(3, "R6 after start");
        c_mstart = 1'b0; set_cfg();

        // R12 and R10: mask and interrupt
        bwr(8'h04, 32'h7F);
        bwr(8'h08, 32'h10);
        brd(8'h10, v); check(v, 32'h10, "R12 mask set");
        check({31'b0, irq}, 32'h0, "R12 irq low rx empty");
        push_byte(8'h96, 1'b1); wait_bytes(1);
        check({31'b0, irq}, 32'h1, "R12 irq on rx data");
        bwr(8'h0C, 32'h10);
        brd(8'h10, v); check(v, 32'h0, "R12 mask clear");
        check({31'b0, irq}, 32'h0, "R12 irq masked");
        bwr(8'h08, 32'h02);
        check({31'b0, irq}, 32'h1, "R12 irq on done");
        bwr(8'h04, 32'h02);
        check({31'b0, irq}, 32'h0, "R10 irq after clear");
        bwr(8'h0C, 32'h7F);
        drain(1, "R11 pop");

        // R8/R9/R10/R11: fill, overflow both queues, drain
        c_code = 3'd0; set_cfg();
        bwr(8'h14, 32'h0);
        for (int j = 0; j < 128; j++) push_byte(8'(j * 37 + 5), 1'b1);
        bwr(8'h1C, 32'h5A);
        brd(8'h04, v); check(v & 32'h4C, 32'h48, "R9 tx overflow and R8 full");
        bwr(8'h04, 32'h40);
        brd(8'h04, v); check(v & 32'h48, 32'h08, "R10 clear keeps level");
        bwr(8'h14, 32'h1);
        wait_bytes(128);
        brd(8'h04, v); check(v & 32'h34, 32'h34, "R8 rx full");
        push_byte(8'hEE, 1'b0); wait_bytes(1);
        brd(8'h04, v); check(v & 32'h01, 32'h01, "R9 rx overflow");
        drain(128, "R11 ordered drain");
        brd(8'h20, v); check(v, 32'h0, "R11 empty read");
        brd(8'h04, v); check(v & 32'h30, 32'h0, "R8 rx empty");

        // R7: clearing enable aborts the byte in flight
        mon_resync = 1'b1;
        c_code = 3'd7; c_cpol = 1'b1; set_cfg(); mon_resync = 1'b1;
        push_byte(8'hA7, 1'b0); push_byte(8'h19, 1'b0);
        repeat (300) @(negedge clk);
        bwr(8'h14, 32'h0);
        repeat (2) @(negedge clk);
        check({31'b0, sclk}, 32'h1, "R7 sclk idle after halt");
        repeat (5000) @(negedge clk);
        brd(8'h04, v); check(v & 32'h10, 32'h0, "R7 no byte received");

        finish_run();
    end
endmodule